// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of lock cells that two independent ports (left and right) share. Each cell arbitrates one shared resource and sits apart from any data storage. A port asks for a lock by writing a zero to the cell and gives it up by writing a one. It learns whether it holds the lock by reading the cell. A zero read back means the port holds it, and a one means it does not.

Each cell keeps a separate request bit for each side. A request made while the other side holds the lock stays pending. When the holder lets go, the waiting side takes over on the next clock edge. If both sides ask for a free cell in the same cycle, the left side wins. Each port's read result is captured in a port-local register and copied onto every data bit. Later writes, including writes from the opposite port, cannot disturb it until that port reads again.

The lock cells have no reset. Software frees each cell by writing a one to it from both sides before the bank is used. The reset input clears only the two read registers.

Top module: `duo_lock_bank`

## Requirements
- R1: The lowest three address bits pick one of eight cells. All higher address bits have no effect.
- R2: A write uses only write-data bit 0, where 0 requests and 1 releases. All other write-data bits are ignored.
- R3: When a side requests a cell that no one holds, that side reads 0 and the other side reads 1 from the next cycle on.
- R4: A request from the side that does not hold a cell leaves the holder unchanged. The request stays pending.
- R5: When the holder releases and the other side has a pending request, the other side holds the cell from the next cycle. Without a pending request, both sides read 1.
- R6: A read copies the port's ownership bit (0 = held by this port) onto all DATA_W bits of its read bus one cycle after the read strobe. The copied value is the state before any write in the same cycle.
- R7: A port's read bus holds its value in every cycle without a read strobe on that port, whatever the other port writes.
- R8: When both sides request the same free cell in one cycle, the left side holds it and the right side is left pending.
- R9: A release from a side that does not hold the cell only clears that side's own pending request.
- R10: The reset input sets both read buses to all ones and leaves the cells untouched. After a one is written from both sides, every cell reads 1 on both ports.
- R11: Read and write strobes on a port have no effect while that port's select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the read registers only |
| lSel | input | 1 | Left port lock-bank select |
| lAddr | input | ADDR_W | Left port address, low 3 bits pick the cell |
| lWr | input | 1 | Left port write strobe |
| lRd | input | 1 | Left port read strobe |
| lWdata | input | DATA_W | Left port write data, bit 0 used |
| lRdata | output | DATA_W | Left port registered read result |
| rSel | input | 1 | Right port lock-bank select |
| rAddr | input | ADDR_W | Right port address, low 3 bits pick the cell |
| rWr | input | 1 | Right port write strobe |
| rRd | input | 1 | Right port read strobe |
| rWdata | input | DATA_W | Right port write data, bit 0 used |
| rRdata | output | DATA_W | Right port registered read result |

## Verification
A corrupted request or tie-break bit inside a cell shows up at the next read of that cell from either port. The symptom is a read of 0 on both sides, a read of 1 on both sides while a request stands, or a lost handover after a release. A read issued one cycle after the faulty write exposes it. A fault in the output register shows as mixed bits on the read bus, or as a change on a port that issued no read.

// File: rtl/duo_lock_pkg.sv
package duo_lock_pkg;
  localparam int unsigned SEM_COUNT = 8;
  localparam int unsigned SEM_IDX_W = $clog2(SEM_COUNT);

  typedef struct packed {
    logic [SEM_COUNT-1:0] lReq;
    logic [SEM_COUNT-1:0] lRel;
    logic [SEM_COUNT-1:0] rReq;
    logic [SEM_COUNT-1:0] rRel;
    logic                 lRd;
    logic                 rRd;
    logic [SEM_IDX_W-1:0] lIdx;
    logic [SEM_IDX_W-1:0] rIdx;
  } lock_strobe_t;
endpackage

// File: rtl/duo_lock_ctrl.sv
module duo_lock_ctrl
  import duo_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              lSel,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWr,
  input  logic              lRd,
  input  logic [DATA_W-1:0] lWdata,
  input  logic              rSel,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWr,
  input  logic              rRd,
  input  logic [DATA_W-1:0] rWdata,
  output lock_strobe_t      strobes
);
  // Upper address bits and upper data bits carry no meaning here.
  logic unusedBits;
  assign unusedBits = ^{lAddr[ADDR_W-1:SEM_IDX_W], rAddr[ADDR_W-1:SEM_IDX_W],
                        lWdata[DATA_W-1:1], rWdata[DATA_W-1:1]};

  always_comb begin
    strobes      = '0;
    strobes.lIdx = lAddr[SEM_IDX_W-1:0];
    strobes.rIdx = rAddr[SEM_IDX_W-1:0];
    strobes.lRd  = lSel & lRd;
    strobes.rRd  = rSel & rRd;
    if (lSel && lWr) begin
      if (lWdata[0]) strobes.lRel[strobes.lIdx] = 1'b1;
      else           strobes.lReq[strobes.lIdx] = 1'b1;
    end
    if (rSel && rWr) begin
      if (rWdata[0]) strobes.rRel[strobes.rIdx] = 1'b1;
      else           strobes.rReq[strobes.rIdx] = 1'b1;
    end
  end
endmodule

// File: rtl/duo_lock_dp.sv
module duo_lock_dp
  import duo_lock_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  lock_strobe_t         strobes,
  output logic [DATA_W-1:0]    lRdata,
  output logic [DATA_W-1:0]    rRdata,
  output logic [SEM_COUNT-1:0] lOwn,
  output logic [SEM_COUNT-1:0] rOwn,
  output logic [SEM_COUNT-1:0] rWait
);
  for (genvar g = 0; g < SEM_COUNT; g++) begin : g_cell
    logic reqL, reqR, tieR;
    logic nextL, nextR;
    assign nextL = (reqL | strobes.lReq[g]) & ~strobes.lRel[g];
    assign nextR = (reqR | strobes.rReq[g]) & ~strobes.rRel[g];

    // No reset: cells are freed by software writes.
    always_ff @(posedge clk) begin
      reqL <= nextL;
      reqR <= nextR;
      // tieR names the holder when both request bits end up set:
      // an earlier lone requester keeps it, a fresh tie goes left.
      tieR <= (reqL & reqR) ? tieR : (reqR & ~reqL);
    end

    assign lOwn[g]  = reqL & (~reqR | ~tieR);
    assign rOwn[g]  = reqR & (~reqL | tieR);
    assign rWait[g] = reqR & ~rOwn[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lRdata <= '1;
      rRdata <= '1;
    end else begin
      if (strobes.lRd) lRdata <= {DATA_W{~lOwn[strobes.lIdx]}};
      if (strobes.rRd) rRdata <= {DATA_W{~rOwn[strobes.rIdx]}};
    end
  end
endmodule

// File: rtl/duo_lock_bank.sv
module duo_lock_bank
  import duo_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lSel,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lWr,
  input  logic              lRd,
  input  logic [DATA_W-1:0] lWdata,
  output logic [DATA_W-1:0] lRdata,
  input  logic              rSel,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rWr,
  input  logic              rRd,
  input  logic [DATA_W-1:0] rWdata,
  output logic [DATA_W-1:0] rRdata
);
  lock_strobe_t         strobes;
  logic [SEM_COUNT-1:0] lOwnVec, rOwnVec, rWaitVec;

  duo_lock_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .lSel(lSel), .lAddr(lAddr), .lWr(lWr), .lRd(lRd), .lWdata(lWdata),
    .rSel(rSel), .rAddr(rAddr), .rWr(rWr), .rRd(rRd), .rWdata(rWdata),
    .strobes(strobes)
  );

  duo_lock_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .lRdata(lRdata), .rRdata(rRdata),
    .lOwn(lOwnVec), .rOwn(rOwnVec), .rWait(rWaitVec)
  );
endmodule

// File: rtl/duo_lock_chk.sv
module duo_lock_chk
  import duo_lock_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 lSel,
  input logic [SEM_IDX_W-1:0] lIdx,
  input logic                 lWr,
  input logic                 lRd,
  input logic                 lBit0,
  input logic [DATA_W-1:0]    lRdata,
  input logic                 rSel,
  input logic [SEM_IDX_W-1:0] rIdx,
  input logic                 rWr,
  input logic                 rRd,
  input logic                 rBit0,
  input logic [DATA_W-1:0]    rRdata,
  input logic [SEM_COUNT-1:0] lOwnVec,
  input logic [SEM_COUNT-1:0] rOwnVec,
  input logic [SEM_COUNT-1:0] rWaitVec
);
  logic lReqNow, lRelNow, rReqNow, rWrNow, lRdNow, rRdNow, sameCell;
  assign lReqNow  = lSel && lWr && !lBit0;
  assign lRelNow  = lSel && lWr && lBit0;
  assign rReqNow  = rSel && rWr && !rBit0;
  assign rWrNow   = rSel && rWr;
  assign lRdNow   = lSel && lRd;
  assign rRdNow   = rSel && rRd;
  assign sameCell = (lIdx == rIdx);

  // R4
  single_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lOwnVec & rOwnVec) == '0);

  // R3
  free_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lReqNow && !lOwnVec[lIdx] && !rOwnVec[lIdx] && !(rWrNow && sameCell)
    |=> lOwnVec[$past(lIdx)] && !rOwnVec[$past(lIdx)]);

  // R5
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lRelNow && lOwnVec[lIdx] && rWaitVec[lIdx] && !(rWrNow && sameCell)
    |=> rOwnVec[$past(lIdx)]);

  // R8
  left_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lReqNow && rReqNow && sameCell && !lOwnVec[lIdx] && !rOwnVec[lIdx]
    |=> lOwnVec[$past(lIdx)]);

  // R6
  l_read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lRdNow |=> lRdata == {DATA_W{~$past(lOwnVec[lIdx])}});

  // R6
  r_read_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rRdNow |=> rRdata == {DATA_W{~$past(rOwnVec[rIdx])}});

  // R7
  l_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lRdNow |=> $stable(lRdata));

  // R7
  r_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rRdNow |=> $stable(rRdata));
endmodule

bind duo_lock_bank duo_lock_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lSel(lSel), .lIdx(lAddr[duo_lock_pkg::SEM_IDX_W-1:0]), .lWr(lWr), .lRd(lRd),
  .lBit0(lWdata[0]), .lRdata(lRdata),
  .rSel(rSel), .rIdx(rAddr[duo_lock_pkg::SEM_IDX_W-1:0]), .rWr(rWr), .rRd(rRd),
  .rBit0(rWdata[0]), .rRdata(rRdata),
  .lOwnVec(lOwnVec), .rOwnVec(rOwnVec), .rWaitVec(rWaitVec)
);

// File: tb/duo_lock_bank_test.sv
`timescale 1ns/1ps
module duo_lock_bank_test;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int STEPS  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lSel = 0, lWr = 0, lRd = 0, rSel = 0, rWr = 0, rRd = 0;
  logic [ADDR_W-1:0] lAddr = '0, rAddr = '0;
  logic [DATA_W-1:0] lWdata = '0, rWdata = '0;
  logic [DATA_W-1:0] lRdata, rRdata;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  duo_lock_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .lSel(lSel), .lAddr(lAddr), .lWr(lWr), .lRd(lRd), .lWdata(lWdata), .lRdata(lRdata),
    .rSel(rSel), .rAddr(rAddr), .rWr(rWr), .rRd(rRd), .rWdata(rWdata), .rRdata(rRdata)
  );

  typedef struct packed {
    logic       lEn;
    logic [7:0] lD;
    logic       rEn;
    logic [7:0] rD;
    logic [2:0] idx;
    logic       expL;
    logic       expR;
  } step_t;

  // Each step: optional writes on both ports to one cell, then a read from both.
  localparam step_t STEP_TAB [STEPS] = '{
    '{1'b1, 8'h00, 1'b0, 8'h00, 3'd3, 1'b0, 1'b1},  // R3 left takes free cell
    '{1'b0, 8'h00, 1'b1, 8'h00, 3'd3, 1'b0, 1'b1},  // R4 right waits
    '{1'b0, 8'h00, 1'b1, 8'hFF, 3'd3, 1'b0, 1'b1},  // R9 right cancels wait
    '{1'b0, 8'h00, 1'b1, 8'h00, 3'd3, 1'b0, 1'b1},  // R4 right waits again
    '{1'b1, 8'h01, 1'b0, 8'h00, 3'd3, 1'b1, 1'b0},  // R5 handover to right
    '{1'b1, 8'hFF, 1'b0, 8'h00, 3'd3, 1'b1, 1'b0},  // R9 stray left release
    '{1'b0, 8'h00, 1'b1, 8'h01, 3'd3, 1'b1, 1'b1},  // R5 release to free
    '{1'b1, 8'h00, 1'b1, 8'h00, 3'd3, 1'b0, 1'b1},  // R8 tie goes left
    '{1'b1, 8'hFF, 1'b0, 8'h00, 3'd3, 1'b1, 1'b0},  // R5 loser takes over
    '{1'b0, 8'h00, 1'b1, 8'hFF, 3'd3, 1'b1, 1'b1},  // R5 free again
    '{1'b0, 8'h00, 1'b1, 8'h00, 3'd5, 1'b1, 1'b0},  // R3 right takes cell 5
    '{1'b1, 8'hFE, 1'b0, 8'h00, 3'd5, 1'b1, 1'b0},  // R2 0xFE is a request
    '{1'b0, 8'h00, 1'b1, 8'h81, 3'd5, 1'b0, 1'b1},  // R2 0x81 is a release
    '{1'b1, 8'h01, 1'b0, 8'h00, 3'd5, 1'b1, 1'b1}   // R2 0x01 releases
  };
  string stepTag [STEPS] = '{"R3", "R4", "R9", "R4", "R5", "R9", "R5",
                             "R8", "R5", "R5", "R3", "R2", "R2", "R2"};

  task automatic check(input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic ls, input logic lw, input logic lr,
                       input logic [ADDR_W-1:0] la, input logic [DATA_W-1:0] ld,
                       input logic rs, input logic rw, input logic rr,
                       input logic [ADDR_W-1:0] ra, input logic [DATA_W-1:0] rd);
    @(negedge clk);
    lSel = ls; lWr = lw; lRd = lr; lAddr = la; lWdata = ld;
    rSel = rs; rWr = rw; rRd = rr; rAddr = ra; rWdata = rd;
    @(negedge clk);
    lSel = 0; lWr = 0; lRd = 0; rSel = 0; rWr = 0; rRd = 0;
  endtask

  task automatic readBoth(input logic [ADDR_W-1:0] la, input logic [ADDR_W-1:0] ra);
    drive(1, 0, 1, la, '0, 1, 0, 1, ra, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset value of both read buses
    check("R10", "left after reset", lRdata, '1);
    check("R10", "right after reset", rRdata, '1);
    rst_n = 1'b1;

    // R10 software initialisation from both sides, then every cell is free
    for (int i = 0; i < 8; i++)
      drive(1, 1, 0, ADDR_W'(i), 8'h01, 1, 1, 0, ADDR_W'(i), 8'h01);
    for (int i = 0; i < 8; i++) begin
      readBoth(ADDR_W'(i), ADDR_W'(i));
      check("R10", $sformatf("left cell %0d free", i), lRdata, '1);
      check("R10", $sformatf("right cell %0d free", i), rRdata, '1);
    end

    // Vector walk; upper address bits differ per port (R1)
    for (int s = 0; s < STEPS; s++) begin
      step_t e = STEP_TAB[s];
      logic [ADDR_W-1:0] la = {9'h1A5, e.idx};
      logic [ADDR_W-1:0] ra = {9'h0C3, e.idx};
      drive(e.lEn, e.lEn, 0, la, e.lD, e.rEn, e.rEn, 0, ra, e.rD);
      readBoth(la, ra);
      check(stepTag[s], $sformatf("step %0d left", s), lRdata, {DATA_W{e.expL}});
      check(stepTag[s], $sformatf("step %0d right", s), rRdata, {DATA_W{e.expR}});
    end

    // R11 write strobe with select low is ignored
    drive(0, 1, 0, 12'h006, 8'h00, 0, 1, 0, 12'h006, 8'h00);
    readBoth(12'h006, 12'h006);
    check("R11", "left unselected write", lRdata, '1);
    check("R11", "right unselected write", rRdata, '1);
    // R11 read strobe with select low leaves read bus alone
    drive(1, 1, 0, 12'h006, 8'h00, 0, 0, 0, '0, '0);   // left takes cell 6
    drive(0, 0, 1, 12'h006, '0, 0, 0, 0, '0, '0);      // unselected read
    check("R11", "left unselected read", lRdata, '1);
    drive(1, 1, 0, 12'h006, 8'h01, 0, 0, 0, '0, '0);

    // R1 upper address bits ignored across both ports
    drive(1, 1, 0, 12'hFF2, 8'h00, 0, 0, 0, '0, '0);
    readBoth(12'h002, 12'h7AA);
    check("R1", "left alias cell 2", lRdata, '0);
    check("R1", "right alias cell 2", rRdata, '1);
    drive(1, 1, 0, 12'h00A, 8'h01, 0, 0, 0, '0, '0);

    // R6 read in the same cycle as own request sees the earlier state
    drive(1, 1, 1, 12'h000, 8'h00, 0, 0, 0, '0, '0);
    check("R6", "read with same-cycle write", lRdata, '1);
    readBoth(12'h000, 12'h000);
    check("R6", "read after write", lRdata, '0);
    drive(1, 1, 0, 12'h000, 8'h01, 0, 0, 0, '0, '0);

    // R7 held read value survives the other port's release
    drive(0, 0, 0, '0, '0, 1, 1, 0, 12'h004, 8'h00);   // right takes cell 4
    drive(1, 1, 0, 12'h004, 8'h00, 0, 0, 0, '0, '0);   // left waits
    drive(1, 0, 1, 12'h004, '0, 0, 0, 0, '0, '0);      // left reads: not held
    check("R7", "left before release", lRdata, '1);
    drive(0, 0, 0, '0, '0, 1, 1, 0, 12'h004, 8'h01);   // right releases
    check("R7", "left held after other release", lRdata, '1);
    drive(1, 0, 1, 12'h004, '0, 0, 0, 0, '0, '0);
    check("R5", "left owns after handover", lRdata, '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule